// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches banks of 32 general-purpose input pins and turns selected pin conditions into one interrupt request. Each pin is first brought into the clock domain by a two-stage synchronizer. Each pin then has its own detection mode. Level mode reports while the pin is at a chosen level. Edge mode reports on a rising edge, on a falling edge, or on both edges. A detected condition sets a sticky pending bit. Software clears a pending bit by writing a one to it.

Each pin also has a mask bit. Software changes the mask through two write-only strobes. One strobe unmasks the selected pins and the other masks them. A separate read-only view returns the current mask. The interrupt output is the registered OR, over every bank, of the pending bits whose pins are unmasked.

The block sits behind a simple word-addressed register port. It has one write strobe, one read strobe and a registered read data path. Every bank has a register group of the same shape, and each group starts a fixed stride above the one before it.

Top module: `gpio_irq_detect`

## Requirements
- R1: The word address is {bank, offset}, with a 3-bit offset, so each bank occupies a stride of 8 words. The offsets are: 0 unmask strobe, 1 mask strobe, 2 mask view, 3 pending, 4 mode select, 5 polarity, 6 both-edge. Offsets 0, 1 and 7 read as zero. Read data appears one clock after the read strobe.
- R2: Writing offset 0 clears the mask bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their mask bit.
- R3: Writing offset 1 sets the mask bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their mask bit.
- R4: Reading offset 2 returns 1 for a masked pin and 0 for an unmasked pin.
- R5: Writing a 1 to a pending bit at offset 3 clears that bit, unless the pin detects a new condition in the same cycle. Writing a 0 leaves the bit unchanged.
- R6: A pin with mode bit 0 is level sensitive. With polarity 1 it sets pending while the pin is high, and with polarity 0 while the pin is low.
- R7: A pin with mode bit 1 and both-edge bit 0 is edge sensitive. With polarity 1 it sets pending on a rising edge, and with polarity 0 on a falling edge.
- R8: A pin with mode bit 1 and both-edge bit 1 sets pending on every rising and every falling edge, whatever its polarity.
- R9: Pending bits latch even while their pin is masked. The irq output is high exactly when some bank has a pending bit whose mask bit is 0, delayed by one register.
- R10: A level-sensitive pin that is still active reads as pending again right after it is cleared. An edge-sensitive pin stays cleared.
- R11: After reset, every pin is masked, the mode, polarity and both-edge bits are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_BANKS*PIN_W | Raw pin inputs; bank b uses bits [b*PIN_W +: PIN_W] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address {bank, offset} |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Random rounds load both banks with random mode, polarity, both-edge and mask words. In each round every pin steps through a random level pair, and the bench compares the pending and irq results with a model built from the requirements. The mix of rising, falling, steady-high and steady-low pins separates level detection from single-edge detection and single-edge detection from both-edge detection. It also separates the polarity sense, and a bank-swapped mode would show as a mismatch between the two banks. Directed cases cover the reset view and the strobes that leave unselected mask bits alone. They also cover a level pin re-pending after a clear while an edge pin stays clear, and a masked pending bit that keeps irq low until its pin is unmasked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_UNMASK = 3'd0,
    OFF_MASK   = 3'd1,
    OFF_MVIEW  = 3'd2,
    OFF_PEND   = 3'd3,
    OFF_MODE   = 3'd4,
    OFF_POL    = 3'd5,
    OFF_BOTH   = 3'd6,
    OFF_RSVD   = 3'd7
  } reg_off_e;

endpackage

// File: rtl/gpio_sync_2ff.sv
module gpio_sync_2ff #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  output logic [W-1:0] evt_o
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pin
      logic lvl_hit;
      logic edge_any;
      logic edge_hit;
      always_comb begin
        lvl_hit  = (cur_i[gi] == pol_i[gi]);
        edge_any = cur_i[gi] ^ prev_i[gi];
        edge_hit = edge_any & (both_i[gi] | (cur_i[gi] == pol_i[gi]));
        evt_o[gi] = mode_i[gi] ? edge_hit : lvl_hit;
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     evt_i,
  output logic [W-1:0]     mask_o,
  output logic [W-1:0]     pend_o,
  output logic [W-1:0]     mode_o,
  output logic [W-1:0]     pol_o,
  output logic [W-1:0]     both_o
);

  logic [W-1:0] mask_q, pend_q, mode_q, pol_q, both_q;
  logic on_stb, off_stb, clr_stb, mode_stb, pol_stb, both_stb;
  logic [W-1:0] clr_bits;

  always_comb begin
    on_stb   = wr_hit_i && (off_i == OFF_UNMASK);
    off_stb  = wr_hit_i && (off_i == OFF_MASK);
    clr_stb  = wr_hit_i && (off_i == OFF_PEND);
    mode_stb = wr_hit_i && (off_i == OFF_MODE);
    pol_stb  = wr_hit_i && (off_i == OFF_POL);
    both_stb = wr_hit_i && (off_i == OFF_BOTH);
    clr_bits = clr_stb ? wdata_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pend_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else begin
      if (on_stb)        mask_q <= mask_q & ~wdata_i;
      else if (off_stb)  mask_q <= mask_q | wdata_i;
      pend_q <= (pend_q & ~clr_bits) | evt_i;
      if (mode_stb) mode_q <= wdata_i;
      if (pol_stb)  pol_q  <= wdata_i;
      if (both_stb) both_q <= wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign both_o = both_q;

  AST_UNMASK_SELECTED: assert property (@(posedge clk) disable iff (rst)
    on_stb |=> ((mask_q & $past(wdata_i)) == '0)); // R2
  AST_UNMASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    on_stb |=> ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i)))); // R2
  AST_MASK_SELECTED: assert property (@(posedge clk) disable iff (rst)
    off_stb |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((pend_q & $past(wdata_i) & ~$past(evt_i)) == '0)); // R5
  AST_PEND_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0)); // R9

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int unsigned ADDR_W    = BANK_W + OFF_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS*PIN_W-1:0] pin_i,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [PIN_W-1:0]           bus_wdata,
  output logic [PIN_W-1:0]           bus_rdata,
  output logic                       irq_o
);

  localparam int unsigned TOTAL_PINS = NUM_BANKS * PIN_W;

  logic [BANK_W-1:0]     bank_sel;
  logic [OFF_W-1:0]      off_sel;
  logic [TOTAL_PINS-1:0] sync_w, prev_w, evt_w;
  logic [TOTAL_PINS-1:0] mask_w, pend_w, mode_w, pol_w, both_w;
  logic [NUM_BANKS-1:0]  bank_active;
  logic [PIN_W-1:0]      rd_mux;
  logic [PIN_W-1:0]      rdata_q;
  logic                  irq_q;

  assign bank_sel = bus_addr[ADDR_W-1:OFF_W];
  assign off_sel  = bus_addr[OFF_W-1:0];

  gpio_sync_2ff #(.W(TOTAL_PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (pin_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic hit;
      assign hit = bus_wr && (bank_sel == BANK_W'(gb));

      gpio_evt_detect #(.W(PIN_W)) u_det (
        .cur_i  (sync_w[gb*PIN_W +: PIN_W]),
        .prev_i (prev_w[gb*PIN_W +: PIN_W]),
        .mode_i (mode_w[gb*PIN_W +: PIN_W]),
        .pol_i  (pol_w[gb*PIN_W +: PIN_W]),
        .both_i (both_w[gb*PIN_W +: PIN_W]),
        .evt_o  (evt_w[gb*PIN_W +: PIN_W])
      );

      gpio_bank_regs #(.W(PIN_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_hit_i (hit),
        .off_i    (off_sel),
        .wdata_i  (bus_wdata),
        .evt_i    (evt_w[gb*PIN_W +: PIN_W]),
        .mask_o   (mask_w[gb*PIN_W +: PIN_W]),
        .pend_o   (pend_w[gb*PIN_W +: PIN_W]),
        .mode_o   (mode_w[gb*PIN_W +: PIN_W]),
        .pol_o    (pol_w[gb*PIN_W +: PIN_W]),
        .both_o   (both_w[gb*PIN_W +: PIN_W])
      );

      assign bank_active[gb] = |(pend_w[gb*PIN_W +: PIN_W] & ~mask_w[gb*PIN_W +: PIN_W]);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BANK_W'(b)) begin
        case (off_sel)
          OFF_MVIEW: rd_mux = mask_w[b*PIN_W +: PIN_W];
          OFF_PEND:  rd_mux = pend_w[b*PIN_W +: PIN_W];
          OFF_MODE:  rd_mux = mode_w[b*PIN_W +: PIN_W];
          OFF_POL:   rd_mux = pol_w[b*PIN_W +: PIN_W];
          OFF_BOTH:  rd_mux = both_w[b*PIN_W +: PIN_W];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= |bank_active;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (rst)
    (&$past(mask_w)) |-> !irq_o); // R9
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_w) == '0) |-> !irq_o); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R1

endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

  localparam int NB = 2;
  localparam int W  = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [NB*W-1:0] pin_i;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  bus_rdata;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NUM_BANKS(NB), .PIN_W(W)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] adr(input int b, input int off);
    return AW'((b << 3) | off);
  endfunction

  function automatic logic [W-1:0] lvl_hit(input logic [W-1:0] v, input logic [W-1:0] md,
                                           input logic [W-1:0] pl);
    return ~md & ~(v ^ pl);
  endfunction

  function automatic logic [W-1:0] edge_hit(input logic [W-1:0] v0, input logic [W-1:0] v1,
                                            input logic [W-1:0] md, input logic [W-1:0] pl,
                                            input logic [W-1:0] bo);
    return md & (v0 ^ v1) & (bo | ~(v1 ^ pl));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] md [NB];
    logic [W-1:0] pl [NB];
    logic [W-1:0] bo [NB];
    logic [W-1:0] mk [NB];
    logic [W-1:0] v0 [NB];
    logic [W-1:0] v1 [NB];
    logic [W-1:0] ex;
    logic         irq_exp;
    void'($urandom(32'd1234));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
    idle(4);
    rst = 1'b0;
    idle(1);

    chk("R11 irq", {31'd0, irq_o}, 32'd0);
    for (int b = 0; b < NB; b++) begin
      rd(adr(b, 2), d); chk("R11 mask", d, 32'hFFFF_FFFF);
      rd(adr(b, 4), d); chk("R11 mode", d, 32'd0);
      rd(adr(b, 5), d); chk("R11 pol", d, 32'd0);
      rd(adr(b, 6), d); chk("R11 both", d, 32'd0);
    end

    // R1: bank separation and reserved reads
    wr(adr(0, 5), 32'hA5A5_0F0F);
    wr(adr(1, 5), 32'h1234_5678);
    rd(adr(0, 5), d); chk("R1 bank0 pol", d, 32'hA5A5_0F0F);
    rd(adr(1, 5), d); chk("R1 bank1 pol", d, 32'h1234_5678);
    rd(adr(0, 7), d); chk("R1 reserved", d, 32'd0);
    rd(adr(1, 0), d); chk("R1 strobe reads 0", d, 32'd0);

    // R2 / R3 / R4: strobes and mask view
    wr(adr(0, 0), 32'h0000_00F0);
    rd(adr(0, 2), d); chk("R2 unmask", d, 32'hFFFF_FF0F);
    wr(adr(0, 0), 32'h0000_0000);
    rd(adr(0, 2), d); chk("R2 zero keeps", d, 32'hFFFF_FF0F);
    wr(adr(0, 1), 32'h0000_0030);
    rd(adr(0, 2), d); chk("R3 mask", d, 32'hFFFF_FF3F);
    rd(adr(1, 2), d); chk("R4 other bank", d, 32'hFFFF_FFFF);
    wr(adr(0, 1), 32'hFFFF_FFFF);

    // R10: pin0 level-high, pin1 rising edge; R9 masked latch
    wr(adr(0, 4), 32'h0000_0002);
    wr(adr(0, 5), 32'h0000_0003);
    wr(adr(0, 6), 32'h0000_0000);
    idle(6);
    wr(adr(0, 3), 32'hFFFF_FFFF);
    pin_i[1:0] = 2'b11;
    idle(6);
    rd(adr(0, 3), d); chk("R6/R7 set", d & 32'h3, 32'h3);
    chk("R9 masked irq low", {31'd0, irq_o}, 32'd0);
    wr(adr(0, 3), 32'h0000_0003);
    rd(adr(0, 3), d); chk("R10 level re-pends, edge clear", d & 32'h3, 32'h1);
    wr(adr(0, 0), 32'h0000_0001);
    idle(3);
    chk("R9 unmask raises irq", {31'd0, irq_o}, 32'd1);
    wr(adr(0, 1), 32'h0000_0001);
    idle(3);
    chk("R9 remask lowers irq", {31'd0, irq_o}, 32'd0);

    // random rounds: R5 R6 R7 R8 R9
    for (int r = 0; r < 30; r++) begin
      for (int b = 0; b < NB; b++) begin
        md[b] = $urandom; pl[b] = $urandom; bo[b] = $urandom; mk[b] = $urandom;
        v0[b] = $urandom; v1[b] = $urandom;
        if (r == 0) begin md[b] = '0; end
        if (r == 1) begin md[b] = '1; bo[b] = '0; end
        if (r == 2) begin md[b] = '1; bo[b] = '1; end
        wr(adr(b, 4), md[b]);
        wr(adr(b, 5), pl[b]);
        wr(adr(b, 6), bo[b]);
        wr(adr(b, 1), 32'hFFFF_FFFF);
        wr(adr(b, 0), ~mk[b]);
      end
      for (int b = 0; b < NB; b++) pin_i[b*W +: W] = v0[b];
      idle(6);
      for (int b = 0; b < NB; b++) wr(adr(b, 3), 32'hFFFF_FFFF);
      idle(2);
      for (int b = 0; b < NB; b++) pin_i[b*W +: W] = v1[b];
      idle(6);
      irq_exp = 1'b0;
      for (int b = 0; b < NB; b++) begin
        ex = lvl_hit(v0[b], md[b], pl[b]) | lvl_hit(v1[b], md[b], pl[b]) |
             edge_hit(v0[b], v1[b], md[b], pl[b], bo[b]);
        if (|(ex & ~mk[b])) irq_exp = 1'b1;
        rd(adr(b, 3), d); chk("R5/R6/R7/R8 pending", d, ex);
        rd(adr(b, 2), d); chk("R4 mask view", d, mk[b]);
      end
      chk("R9 irq", {31'd0, irq_o}, {31'd0, irq_exp});
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule